// File: doc/BRIEF.md
# Two-Wire Serial Memory Read Slave

This block is the target side of a two-wire serial memory bus that answers read accesses from an internal byte array. A fast system clock oversamples the clock line and the data line. The block finds start and stop conditions and compares the 7-bit device address. It acknowledges a matching address and pulls the data line low through an open-drain output enable. An internal 8-bit address pointer selects the byte that is returned.

Three kinds of read are served. A current-address read returns the byte at the pointer. A random read first sends a dummy write that carries one byte address, which loads the pointer, and then reads after a repeated start. A sequential read continues for as long as the master acknowledges each byte on the ninth clock. When the master leaves the ninth bit high and sends a stop, the transfer ends. A side port fills the array before the bus is used.

Top module: `tws_rd_slave`

## Requirements
- R1: A falling data line while the clock line is high is a start, and a rising data line while the clock line is high is a stop. Either one abandons any transfer in progress. After a stop the block waits idle with the data line released, and after a start it expects a device address. After reset the data line is released.
- R2: The first byte after a start holds the 7-bit device address, MSB first, followed by the R/W bit (1 = read). On a match the block pulls the data line low for the ninth clock. On a mismatch it leaves the ninth bit high and then leaves the bus alone until the next start.
- R3: A read addressed to the block returns the byte at the address pointer. After each byte is sent, the pointer becomes that byte's address plus one.
- R4: A matching write (R/W = 0) is followed by one byte address. The block acknowledges that byte address and loads it into the pointer. A repeated start and a read then return the byte at the loaded address.
- R5: When the master pulls the data line low on the ninth clock of a read byte, the block sends the byte at the next address.
- R6: When the master leaves the ninth bit of a read byte high, the block drives nothing more in that transfer. The next current-address read continues from the byte after the last one read.
- R7: The pointer is 8 bits wide, resets to 0 and wraps from 255 to 0.
- R8: The block changes its data line drive only while the clock line is low. Read data goes out MSB first.
- R9: Any byte written after the byte address is not acknowledged and does not change the array.
- R10: A pulse on the preload strobe writes the preload data byte into the array at the preload address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the bus clock rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls the data line low (open drain) |
| pre_we_i | input | 1 | Preload write strobe |
| pre_addr_i | input | 8 | Preload address |
| pre_data_i | input | 8 | Preload data |

## Verification
The assertions check on every cycle the following: the data line drive changes only while the clock line is low, a stop or start forces the idle or address state, the line is released in the idle and ignore states, and the pointer moves only by one step or by a byte-address load. Only the bus-master scenarios can show the following: the returned data matches the array for current, random and sequential reads, the pointer wraps at 255, a mismatched address is never acknowledged, and extra written bytes are refused. A transfer broken off by a stop or a start in mid-byte is also covered only by these scenarios.

// File: rtl/tws_pkg.sv
package tws_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_DEV,
    ST_WADDR,
    ST_ACK_WA,
    ST_RD,
    ST_RD_ACK,
    ST_IGNORE
  } tws_state_e;
endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], d_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign q_o    = chain_q[STAGES-1];
  assign rise_o = q_o & ~prev_q;
  assign fall_o = ~q_o & prev_q;
endmodule

// File: rtl/tws_mem.sv
module tws_mem #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/tws_rd_slave.sv
module tws_rd_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         AW          = 8,
  parameter int         DW          = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  input  logic          pre_we_i,
  input  logic [AW-1:0] pre_addr_i,
  input  logic [DW-1:0] pre_data_i
);
  import tws_pkg::*;

  localparam int CW = $clog2(DW + 1);
  localparam int NL = 2; // 0: clock line, 1: data line

  logic [NL-1:0] line_raw, line_q, line_rise, line_fall;
  assign line_raw = {sda_i, scl_i};

  for (genvar g = 0; g < NL; g++) begin : g_sync
    tws_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (line_raw[g]),
      .q_o   (line_q[g]),
      .rise_o(line_rise[g]),
      .fall_o(line_fall[g])
    );
  end

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  assign scl_s     = line_q[0];
  assign sda_s     = line_q[1];
  assign scl_rise  = line_rise[0];
  assign scl_fall  = line_fall[0];
  assign start_det = scl_s & line_fall[1];
  assign stop_det  = scl_s & line_rise[1];

  tws_state_e    state;
  logic [CW-1:0] bcnt;
  logic [DW-1:0] sr, tx;
  logic [AW-1:0] ptr;
  logic          rw, ack_ph, mack, oe;
  logic [DW-1:0] rdata;
  logic [DW-1:0] sr_next;

  assign sr_next = {sr[DW-2:0], sda_s};

  tws_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk_i  (clk_i),
    .we_i   (pre_we_i),
    .waddr_i(pre_addr_i),
    .wdata_i(pre_data_i),
    .raddr_i(ptr),
    .rdata_o(rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state  <= ST_IDLE;
      bcnt   <= '0;
      sr     <= '0;
      tx     <= '0;
      ptr    <= '0;
      rw     <= 1'b0;
      ack_ph <= 1'b0;
      mack   <= 1'b0;
      oe     <= 1'b0;
    end else if (start_det) begin
      state  <= ST_ADDR;
      bcnt   <= '0;
      ack_ph <= 1'b0;
      oe     <= 1'b0;
    end else if (stop_det) begin
      state  <= ST_IDLE;
      bcnt   <= '0;
      ack_ph <= 1'b0;
      oe     <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR: if (scl_rise) begin
          sr <= sr_next;
          if (bcnt == CW'(DW - 1)) begin
            bcnt <= '0;
            if (sr[6:0] == DEV_ADDR) begin
              rw    <= sda_s;
              state <= ST_ACK_DEV;
            end else begin
              state <= ST_IGNORE;
            end
          end else begin
            bcnt <= bcnt + 1'b1;
          end
        end
        ST_ACK_DEV: if (scl_fall) begin
          if (!ack_ph) begin
            oe     <= 1'b1;
            ack_ph <= 1'b1;
          end else begin
            ack_ph <= 1'b0;
            if (rw) begin
              oe    <= ~rdata[DW-1];
              tx    <= {rdata[DW-2:0], 1'b0};
              bcnt  <= CW'(1);
              state <= ST_RD;
            end else begin
              oe    <= 1'b0;
              bcnt  <= '0;
              state <= ST_WADDR;
            end
          end
        end
        ST_WADDR: if (scl_rise) begin
          sr <= sr_next;
          if (bcnt == CW'(DW - 1)) begin
            bcnt  <= '0;
            ptr   <= AW'(sr_next);
            state <= ST_ACK_WA;
          end else begin
            bcnt <= bcnt + 1'b1;
          end
        end
        ST_ACK_WA: if (scl_fall) begin
          if (!ack_ph) begin
            oe     <= 1'b1;
            ack_ph <= 1'b1;
          end else begin
            oe     <= 1'b0;
            ack_ph <= 1'b0;
            state  <= ST_IGNORE; // further write bytes are refused
          end
        end
        ST_RD: if (scl_fall) begin
          if (bcnt == CW'(DW)) begin
            oe    <= 1'b0;
            ptr   <= ptr + 1'b1;
            bcnt  <= '0;
            state <= ST_RD_ACK;
          end else begin
            oe   <= ~tx[DW-1];
            tx   <= {tx[DW-2:0], 1'b0};
            bcnt <= bcnt + 1'b1;
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) mack <= ~sda_s;
          if (scl_fall) begin
            if (mack) begin
              oe    <= ~rdata[DW-1];
              tx    <= {rdata[DW-2:0], 1'b0};
              bcnt  <= CW'(1);
              state <= ST_RD;
            end else begin
              state <= ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = oe;
endmodule

// File: rtl/tws_rd_slave_chk.sv
module tws_rd_slave_chk
  import tws_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int CW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          scl_i,
  input logic          sda_oe_o,
  input logic          start_det,
  input logic          stop_det,
  input tws_state_e    state,
  input logic [AW-1:0] ptr,
  input logic [CW-1:0] bcnt
);
  AST_DRIVE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_i); // R8

  AST_STOP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det && !start_det |=> state == ST_IDLE); // R1

  AST_START_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> state == ST_ADDR); // R1

  AST_QUIET_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE || state == ST_IGNORE) |-> !sda_oe_o); // R2

  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ptr) |-> (ptr == AW'($past(ptr) + 1'b1)) || ($past(state) == ST_WADDR)); // R7

  AST_BCNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bcnt <= CW'(DW)); // R8
endmodule

bind tws_rd_slave tws_rd_slave_chk #(.AW(AW), .DW(DW), .CW(CW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .scl_i    (scl_i),
  .sda_oe_o (sda_oe_o),
  .start_det(start_det),
  .stop_det (stop_det),
  .state    (state),
  .ptr      (ptr),
  .bcnt     (bcnt)
);

// File: tb/sim_tws_rd_slave.sv
module sim_tws_rd_slave;
  localparam logic [6:0] DEV = 7'h50;
  localparam int HP = 8;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  logic pre_we = 1'b0;
  logic [7:0] pre_addr = '0, pre_data = '0;
  logic sda_oe;
  wire  sda_bus = sda_m & ~sda_oe;

  always #4 clk = ~clk; // 125 MHz

  tws_rd_slave #(.DEV_ADDR(DEV)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .pre_we_i(pre_we), .pre_addr_i(pre_addr), .pre_data_i(pre_data)
  );

  int checks = 0, errors = 0, r8_viol = 0;
  logic [7:0] ref_mem [256];
  logic [7:0] eptr = '0;
  logic [7:0] exp_q[$], act_q[$];
  string      tag_q[$];
  bit         done = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    while (act_q.size() > 0 && exp_q.size() > 0) begin
      automatic logic [7:0] a = act_q.pop_front();
      automatic logic [7:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      check(a === e, t, a, e);
    end
  end

  // drive changes while clock high are tallied for R8
  initial begin
    logic prev_oe = 1'b0;
    forever begin
      @(posedge clk); #1;
      if (rst_n && scl_m && sda_oe !== prev_oe) r8_viol++;
      prev_oe = sda_oe;
    end
  end

  task automatic hwait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hwait(HP);
    scl_m = 1'b1; hwait(HP);
    sda_m = 1'b0; hwait(HP);
    scl_m = 1'b0; hwait(2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hwait(HP);
    scl_m = 1'b1; hwait(HP);
    sda_m = 1'b1; hwait(HP);
  endtask

  task automatic wr_bit(input logic b);
    sda_m = b; hwait(HP);
    scl_m = 1'b1; hwait(HP);
    scl_m = 1'b0; hwait(2);
  endtask

  task automatic rd_bit(output logic b);
    sda_m = 1'b1; hwait(HP);
    scl_m = 1'b1; hwait(HP/2);
    b = sda_bus; hwait(HP/2);
    scl_m = 1'b0; hwait(2);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) wr_bit(v[i]);
    rd_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      rd_bit(b);
      d[i] = b;
    end
    wr_bit(~give_ack);
  endtask

  task automatic rd_seq(input int n, input string tag);
    logic [7:0] d;
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(ref_mem[eptr]);
      tag_q.push_back(tag);
      eptr = eptr + 8'd1;
      recv_byte(k < n - 1, d);
      act_q.push_back(d);
    end
  endtask

  task automatic cur_read(input int n, input string tag);
    logic ack;
    bus_start();
    send_byte({DEV, 1'b1}, ack);
    check(ack, "R2 read address ack", ack, 1);
    rd_seq(n, tag);
    bus_stop();
  endtask

  task automatic rand_read(input logic [7:0] a, input int n, input string tag);
    logic ack;
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    check(ack, "R2 write address ack", ack, 1);
    send_byte(a, ack);
    check(ack, "R4 byte address ack", ack, 1);
    eptr = a;
    bus_start();
    send_byte({DEV, 1'b1}, ack);
    check(ack, "R4 repeated start address ack", ack, 1);
    rd_seq(n, tag);
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ack, b;
    logic [7:0] d;
    for (int i = 0; i < 256; i++) ref_mem[i] = 8'((i * 37 + 11) & 255);
    hwait(5);
    check(sda_oe === 1'b0, "R1 released in reset", sda_oe, 0);
    rst_n = 1'b1;
    hwait(3);
    // R10 preload
    for (int i = 0; i < 256; i++) begin
      pre_we = 1'b1; pre_addr = 8'(i); pre_data = ref_mem[i];
      hwait(1);
    end
    pre_we = 1'b0;
    hwait(HP);

    cur_read(1, "R3 R7 R10 first read from 0");
    cur_read(1, "R6 next read continues at n+1");
    rand_read(8'h40, 1, "R4 random read");
    rand_read(8'h80, 4, "R5 sequential read");
    cur_read(2, "R6 current read after sequential");
    rand_read(8'hFE, 3, "R7 pointer wrap");

    // R2 mismatched address: no ack, data line untouched
    bus_start();
    send_byte({7'h23, 1'b1}, ack);
    check(!ack, "R2 mismatch not acked", ack, 0);
    for (int i = 7; i >= 0; i--) begin
      rd_bit(b);
      d[i] = b;
    end
    check(d == 8'hFF, "R2 bus ignored after mismatch", d, 8'hFF);
    bus_stop();
    cur_read(1, "R2 pointer untouched by mismatch");

    // R9 extra write byte refused
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    check(ack, "R9 write address ack", ack, 1);
    send_byte(8'h10, ack);
    check(ack, "R4 byte address ack", ack, 1);
    send_byte(8'h99, ack);
    check(!ack, "R9 data byte not acked", ack, 0);
    bus_stop();
    eptr = 8'h10;
    cur_read(1, "R9 array unchanged");

    // R1 stop in mid-address, then start in mid-address
    bus_start();
    wr_bit(1'b1); wr_bit(1'b0); wr_bit(1'b1);
    bus_stop();
    cur_read(1, "R1 read after aborted address");
    bus_start();
    wr_bit(1'b1); wr_bit(1'b0); wr_bit(1'b1); wr_bit(1'b0);
    cur_read(1, "R1 read after repeated start abort");
    check(sda_oe === 1'b0, "R1 idle after stop", sda_oe, 0);

    hwait(4);
    check(exp_q.size() == 0, "R3 all reads compared", exp_q.size(), 0);
    check(r8_viol == 0, "R8 drive changes only while clock low", r8_viol, 0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule